// File: doc/BRIEF.md
# Peak-Hold Display Register

This block is the register that feeds a meter's display. Whenever the converter or the frequency counter finishes a measurement, it raises a one-cycle done strobe. The strobe carries a reading in sign-magnitude form: a polarity bit, a 3-3/4 digit BCD magnitude and an over-range flag. The register decides whether to take that reading. It then holds the result without change until it takes another.

With peak capture disabled, the register takes every reading. With peak capture enabled, it keeps the largest reading seen so far. Largeness is judged on magnitude alone, so the sign plays no part in the decision. A held value never decays. It also drives an output that tells the frequency counter's range logic to stop switching ranges while peak capture is on. This is needed because a range change would make the held and new digits incomparable.

Top module: `peak_hold_display`

## Requirements
- R1: After reset the display reads magnitude 0000, positive polarity (0), over-range flag clear.
- R2: The display changes only on the clock edge that samples `rd_valid` high; the loaded value is visible from the next cycle, and with `rd_valid` low the display holds.
- R3: With `hold_en` low, every strobe loads polarity, digits and over-range flag as given, including readings smaller than the one shown.
- R4: With `hold_en` high, an in-range reading is loaded, with its own polarity, only when its magnitude is strictly greater than the held magnitude; polarity does not take part in the comparison.
- R5: With `hold_en` high, a reading whose magnitude equals the held one (either polarity) leaves the display unchanged.
- R6: Magnitudes are compared digit by digit, most significant digit first; `rd_bcd[15:12]` is the most significant (half) digit 0..3 and `rd_bcd[3:0]` the least, each a BCD nibble (e.g. 1000 is greater than 0999).
- R7: With `hold_en` high, an over-range reading is greater than any in-range value and is held with its flag set; while an over-range value is held, no reading (in-range or over-range) replaces it.
- R8: `autorange_off` is high exactly while `hold_en` is high, in the same cycle.
- R9: Lowering `hold_en` does not alter the displayed value; the next strobe after that loads unconditionally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | One-cycle end-of-measurement strobe |
| rd_neg | input | 1 | Polarity of the new reading, 1 = negative |
| rd_bcd | input | 16 | BCD magnitude of the new reading, MS digit in top nibble |
| rd_ovr | input | 1 | New reading is over range |
| hold_en | input | 1 | Peak capture enable |
| disp_neg | output | 1 | Displayed polarity |
| disp_bcd | output | 16 | Displayed BCD magnitude |
| disp_ovr | output | 1 | Displayed over-range flag |
| autorange_off | output | 1 | Inhibit for counter auto-ranging |

## Verification
The display is due one register stage after a strobe. The bench raises `rd_valid` on a falling edge and drops it on the next falling edge. It then reads the display there, half a cycle after the capturing rising edge. The auto-range inhibit is combinational, so it is sampled in the same half cycle in which `hold_en` changes. Checks that a reading was refused are made after the strobe has passed, and are repeated after idle cycles to show the held value stays put.

// File: rtl/peak_hold_display.sv
module peak_hold_display #(
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_neg,
  input  logic [DIGITS*4-1:0] rd_bcd,
  input  logic              rd_ovr,
  input  logic              hold_en,
  output logic              disp_neg,
  output logic [DIGITS*4-1:0] disp_bcd,
  output logic              disp_ovr,
  output logic              autorange_off
);

  localparam int W = DIGITS * 4;

  logic gt_c [DIGITS+1];
  logic eq_c [DIGITS+1];
  logic mag_gt;
  logic load;

  assign gt_c[DIGITS] = 1'b0;
  assign eq_c[DIGITS] = 1'b1;

  for (genvar i = DIGITS - 1; i >= 0; i--) begin : g_cmp
    logic [3:0] d_new, d_old;
    assign d_new   = rd_bcd[i*4 +: 4];
    assign d_old   = disp_bcd[i*4 +: 4];
    assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & (d_new > d_old));
    assign eq_c[i] = eq_c[i+1] & (d_new == d_old);
  end

  assign mag_gt = gt_c[0];

  assign load = rd_valid & (~hold_en
                          | (rd_ovr & ~disp_ovr)
                          | (~rd_ovr & ~disp_ovr & mag_gt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_neg <= 1'b0;
      disp_bcd <= '0;
      disp_ovr <= 1'b0;
    end else if (load) begin
      disp_neg <= rd_neg;
      disp_bcd <= rd_bcd;
      disp_ovr <= rd_ovr;
    end
  end

  assign autorange_off = hold_en;

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable({disp_neg, disp_bcd, disp_ovr}));

  a_r3_free_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !hold_en |=>
      {disp_neg, disp_bcd, disp_ovr} == $past({rd_neg, rd_bcd, rd_ovr}));

  a_r5_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && hold_en && !rd_ovr && !disp_ovr && (rd_bcd <= disp_bcd)
      |=> $stable({disp_neg, disp_bcd, disp_ovr}));

  a_r7_ovr_captured: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && hold_en && rd_ovr |=> disp_ovr);

  a_r7_ovr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en && disp_ovr |=> $stable({disp_neg, disp_bcd, disp_ovr}));

  a_r4_grows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && hold_en && !rd_ovr && !disp_ovr && (rd_bcd > disp_bcd)
      |=> disp_bcd == $past(rd_bcd) && disp_neg == $past(rd_neg));

endmodule

// File: tb/test_peak_hold_display.sv
module test_peak_hold_display;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_neg = 1'b0;
  logic [15:0] rd_bcd = '0;
  logic        rd_ovr = 1'b0;
  logic        hold_en = 1'b0;
  logic        disp_neg;
  logic [15:0] disp_bcd;
  logic        disp_ovr;
  logic        autorange_off;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  peak_hold_display i_peak_hold_display (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_neg(rd_neg),
    .rd_bcd(rd_bcd), .rd_ovr(rd_ovr), .hold_en(hold_en),
    .disp_neg(disp_neg), .disp_bcd(disp_bcd), .disp_ovr(disp_ovr),
    .autorange_off(autorange_off)
  );

  task automatic check_disp(string tag, logic en, logic [15:0] eb, logic ov);
    total++;
    if ({disp_neg, disp_bcd, disp_ovr} !== {en, eb, ov}) begin
      bad++;
      $display("FAIL %s: got neg=%0b bcd=%h ovr=%0b, expected neg=%0b bcd=%h ovr=%0b",
               tag, disp_neg, disp_bcd, disp_ovr, en, eb, ov);
    end
  endtask

  task automatic check_inh(string tag, logic exp);
    total++;
    if (autorange_off !== exp) begin
      bad++;
      $display("FAIL %s: got autorange_off=%0b, expected %0b", tag, autorange_off, exp);
    end
  endtask

  task automatic strobe(logic n, logic [15:0] b, logic ov);
    @(negedge clk);
    rd_valid = 1'b1; rd_neg = n; rd_bcd = b; rd_ovr = ov;
    @(negedge clk);
    rd_valid = 1'b0; rd_neg = 1'b0; rd_bcd = 16'h0000; rd_ovr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic test_reset;
    check_disp("R1 reset value", 1'b0, 16'h0000, 1'b0);
    check_inh("R8 inhibit low at reset", 1'b0);
  endtask

  task automatic test_free_load;
    hold_en = 1'b0;
    strobe(1'b0, 16'h0123, 1'b0);
    check_disp("R3 load 0123", 1'b0, 16'h0123, 1'b0);
    idle(3);
    check_disp("R2 idle holds", 1'b0, 16'h0123, 1'b0);
    @(negedge clk);
    rd_bcd = 16'h3999; rd_ovr = 1'b1;
    @(negedge clk);
    check_disp("R2 no strobe no load", 1'b0, 16'h0123, 1'b0);
    rd_bcd = 16'h0000; rd_ovr = 1'b0;
    strobe(1'b1, 16'h0005, 1'b0);
    check_disp("R3 smaller loads", 1'b1, 16'h0005, 1'b0);
    strobe(1'b0, 16'h2000, 1'b1);
    check_disp("R3 over-range loads", 1'b0, 16'h2000, 1'b1);
    strobe(1'b0, 16'h0042, 1'b0);
    check_disp("R3 in-range replaces ovr", 1'b0, 16'h0042, 1'b0);
    strobe(1'b0, 16'h0000, 1'b0);
    check_disp("R3 load zero", 1'b0, 16'h0000, 1'b0);
  endtask

  task automatic test_peak;
    @(negedge clk);
    hold_en = 1'b1;
    #0.5 check_inh("R8 inhibit follows enable", 1'b1);
    strobe(1'b1, 16'h0250, 1'b0);
    check_disp("R4 larger negative loads", 1'b1, 16'h0250, 1'b0);
    strobe(1'b0, 16'h0100, 1'b0);
    check_disp("R4 smaller refused", 1'b1, 16'h0250, 1'b0);
    strobe(1'b0, 16'h0250, 1'b0);
    check_disp("R5 equal other sign refused", 1'b1, 16'h0250, 1'b0);
    strobe(1'b1, 16'h0250, 1'b0);
    check_disp("R5 equal same sign refused", 1'b1, 16'h0250, 1'b0);
    strobe(1'b0, 16'h0999, 1'b0);
    check_disp("R4 larger positive loads", 1'b0, 16'h0999, 1'b0);
    strobe(1'b1, 16'h1000, 1'b0);
    check_disp("R6 1000 beats 0999", 1'b1, 16'h1000, 1'b0);
    strobe(1'b0, 16'h0999, 1'b0);
    check_disp("R6 0999 below 1000", 1'b1, 16'h1000, 1'b0);
    strobe(1'b0, 16'h1009, 1'b0);
    check_disp("R6 low digit decides", 1'b0, 16'h1009, 1'b0);
    strobe(1'b0, 16'h1008, 1'b0);
    check_disp("R6 low digit smaller", 1'b0, 16'h1009, 1'b0);
    idle(4);
    check_disp("R2 held does not decay", 1'b0, 16'h1009, 1'b0);
  endtask

  task automatic test_overrange;
    strobe(1'b1, 16'h0001, 1'b1);
    check_disp("R7 ovr beats in-range", 1'b1, 16'h0001, 1'b1);
    strobe(1'b0, 16'h3999, 1'b0);
    check_disp("R7 full scale refused", 1'b1, 16'h0001, 1'b1);
    strobe(1'b0, 16'h3999, 1'b1);
    check_disp("R7 second ovr refused", 1'b1, 16'h0001, 1'b1);
  endtask

  task automatic test_release;
    @(negedge clk);
    hold_en = 1'b0;
    #0.5 check_inh("R8 inhibit drops", 1'b0);
    idle(2);
    check_disp("R9 release keeps display", 1'b1, 16'h0001, 1'b1);
    strobe(1'b0, 16'h0001, 1'b0);
    check_disp("R9 next strobe loads", 1'b0, 16'h0001, 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_free_load();
    test_peak();
    test_overrange();
    test_release();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule